// File: doc/BRIEF.md
# Packed Single-Precision Compare Predicate Unit

The unit compares two packed vectors of IEEE-754 single-precision values lane by lane. A 5-bit predicate code picks one of 32 tests. For each lane, the unit first puts the operand pair into one of four relations: less, equal, greater or unordered. It then decides whether the chosen predicate holds for that relation. The lane's result field is filled with all ones when the predicate holds and with all zeros when it does not. The result can be used directly as a select mask for later blend or logic operations.

Each predicate code also carries a quiet-or-signaling attribute, set separately from its boolean test. A signaling predicate reports an invalid-operation event for any NaN operand. A quiet predicate reports it only for signaling NaNs. This holds even for the constant predicates (always false and always true), so they still inspect their operands. The lane flags are OR-ed into one invalid output.

All results are registered. They appear one clock after a cycle with `valid_i` high and hold until the next such cycle.

Top module: `fcmp_packed_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mask_o`, `invalid_o` and `valid_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. `mask_o` and `invalid_o` change only in that cycle and otherwise hold their last values.
- R3: Non-NaN operands are ordered by their signed value. Positive zero and negative zero compare equal. Identical bit patterns compare equal.
- R4: An operand is a NaN when its exponent bits [30:23] are all ones and its mantissa bits [22:0] are nonzero. A lane with a NaN in either operand is unordered. Infinities are ordered normally.
- R5: For codes 0 to 15 the predicate holds for these relations:
  - 0 equal; 1 less; 2 less or equal; 3 unordered.
  - 4 not equal (less, greater or unordered); 5 not less; 6 not less-or-equal; 7 ordered.
  - 8 equal or unordered; 9 not greater-or-equal (less or unordered); 10 not greater.
  - 11 never; 12 less or greater; 13 greater or equal; 14 greater; 15 always.
- R6: Code 16+k uses the same boolean test as code k, for k from 0 to 15.
- R7: Lane i occupies bits [32i+31:32i] of `a_i`, `b_i` and `mask_o`. Each result lane is either all ones or all zeros.
- R8: Codes 1, 2, 5, 6, 9, 10, 13 and 14 are signaling, and the other codes below 16 are quiet. Setting bit 4 of the code inverts this attribute.
- R9: A lane raises invalid under a signaling predicate when either operand is a NaN. It raises invalid under a quiet predicate only when either operand is a signaling NaN, meaning a NaN with mantissa bit 22 clear. This applies to every code, including 11, 15, 27 and 31.
- R10: `invalid_o` is the OR of the invalid flags of all lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | 32*LANES | First operand vector |
| b_i | input | 32*LANES | Second operand vector |
| imm_i | input | 5 | Predicate code |
| valid_i | input | 1 | Operands and code are valid this cycle |
| mask_o | output | 32*LANES | Per-lane all-ones / all-zeros result |
| invalid_o | output | 1 | Invalid-operation flag, OR over lanes |
| valid_o | output | 1 | Result valid, one cycle after valid_i |

## Verification
The bench targets several corner cases, each tied to a typical design mistake:
- **Signed zeros.** A design that compares raw bits would report +0 and -0 as unequal.
- **Ordering of negative values.** A magnitude-only compare would reverse the order of negative values.
- **Infinities.** A loose NaN test would call them unordered.
- **Negated predicates on unordered lanes.** The unordered-true rule of the negated predicates is exercised, where a design that negates "less" using a sign compare would return false.
- **Invalid rules.** Quiet and signaling NaNs are crossed with quiet and signaling codes. A NaN is placed in a single high lane, and the constant predicates are given signaling NaNs. Mistakes here show up as a missing or spurious invalid flag, or as constant predicates that skip the NaN check.

// File: rtl/fcmp_pkg.sv
// Shared constants and types for the packed single-precision compare unit.
// Assumes IEEE-754 binary32 lanes.
package fcmp_pkg;
    localparam int SP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    // Relation of one operand pair; the value indexes a 4-bit truth set.
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;
endpackage

// File: rtl/fcmp_lane_rel.sv
// Classifies one pair of binary32 operands as less, equal, greater or
// unordered, and reports NaN / signaling-NaN presence. Purely combinational.
// Assumes no denormal flushing: denormals are compared by their bits.
module fcmp_lane_rel
    import fcmp_pkg::*;
(
    input  logic [SP_W-1:0] a,
    input  logic [SP_W-1:0] b,
    output rel_e            rel,
    output logic            any_nan,
    output logic            any_snan
);
    logic [SP_W-2:0] a_mag, b_mag;
    logic            a_nan, b_nan, a_snan, b_snan;
    logic            both_zero, a_less;

    // Detect NaN classes from exponent and mantissa fields.
    always_comb begin
        a_mag  = a[SP_W-2:0];
        b_mag  = b[SP_W-2:0];
        a_nan  = (&a[SP_W-2 -: EXP_W]) && (|a[MAN_W-1:0]);
        b_nan  = (&b[SP_W-2 -: EXP_W]) && (|b[MAN_W-1:0]);
        a_snan = a_nan && !a[MAN_W-1];
        b_snan = b_nan && !b[MAN_W-1];
        any_nan  = a_nan || b_nan;
        any_snan = a_snan || b_snan;
    end

    // Sign-magnitude ordering with both zeros treated as equal.
    always_comb begin
        both_zero = (a_mag == '0) && (b_mag == '0);
        unique case ({a[SP_W-1], b[SP_W-1]})
            2'b00:   a_less = a_mag < b_mag;
            2'b11:   a_less = a_mag > b_mag;
            2'b10:   a_less = 1'b1;
            default: a_less = 1'b0;
        endcase
        if (any_nan)
            rel = REL_UN;
        else if ((a == b) || both_zero)
            rel = REL_EQ;
        else if (a_less)
            rel = REL_LT;
        else
            rel = REL_GT;
    end
endmodule

// File: rtl/fcmp_pred_dec.sv
// Decodes the 5-bit predicate code into a truth set over the four relations
// and a signaling attribute. Bit 4 only flips the attribute.
module fcmp_pred_dec (
    input  logic [4:0] code,
    output logic [3:0] holds,     // bit index = fcmp_pkg::rel_e value
    output logic       signaling
);
    // Truth set: {UN, GT, EQ, LT}.
    always_comb begin
        unique case (code[3:0])
            4'd0:  holds = 4'b0010;
            4'd1:  holds = 4'b0001;
            4'd2:  holds = 4'b0011;
            4'd3:  holds = 4'b1000;
            4'd4:  holds = 4'b1101;
            4'd5:  holds = 4'b1110;
            4'd6:  holds = 4'b1100;
            4'd7:  holds = 4'b0111;
            4'd8:  holds = 4'b1010;
            4'd9:  holds = 4'b1001;
            4'd10: holds = 4'b1011;
            4'd11: holds = 4'b0000;
            4'd12: holds = 4'b0101;
            4'd13: holds = 4'b0110;
            4'd14: holds = 4'b0100;
            default: holds = 4'b1111;
        endcase
    end

    // Quiet/signaling pattern repeats every four codes; bit 4 inverts it.
    always_comb begin
        signaling = (code[0] ^ code[1]) ^ code[4];
    end
endmodule

// File: rtl/fcmp_packed_unit.sv
// Packed binary32 compare predicate unit: per-lane relation, predicate
// evaluation to an all-ones/all-zeros mask, and an OR-ed invalid flag.
// Results are registered one cycle after valid_i and held otherwise.
module fcmp_packed_unit
    import fcmp_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES*SP_W-1:0] a_i,
    input  logic [LANES*SP_W-1:0] b_i,
    input  logic [4:0]            imm_i,
    input  logic                  valid_i,
    output logic [LANES*SP_W-1:0] mask_o,
    output logic                  invalid_o,
    output logic                  valid_o
);
    localparam int VEC_W = LANES * SP_W;

    logic [3:0]       holds;
    logic             signaling;
    logic [VEC_W-1:0] mask_d;
    logic [LANES-1:0] lane_inv;

    fcmp_pred_dec u_dec (
        .code      (imm_i),
        .holds     (holds),
        .signaling (signaling)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rel_e rel;
        logic nan_any, snan_any;

        fcmp_lane_rel u_rel (
            .a        (a_i[i*SP_W +: SP_W]),
            .b        (b_i[i*SP_W +: SP_W]),
            .rel      (rel),
            .any_nan  (nan_any),
            .any_snan (snan_any)
        );

        // Apply predicate to the lane relation and pick the invalid rule.
        always_comb begin
            mask_d[i*SP_W +: SP_W] = {SP_W{holds[rel]}};
            lane_inv[i] = signaling ? nan_any : snan_any;
        end
    end

    // Capture results on valid, hold otherwise; valid_o tracks valid_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o    <= '0;
            invalid_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                mask_o    <= mask_d;
                invalid_o <= |lane_inv;
            end
        end
    end
endmodule

// File: rtl/fcmp_packed_chk.sv
// Assertion checker for fcmp_packed_unit, attached with bind below.
// Observes only the unit's ports.
module fcmp_packed_chk #(
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LANES*32-1:0] a_i,
    input logic [LANES*32-1:0] b_i,
    input logic [4:0]          imm_i,
    input logic                valid_i,
    input logic [LANES*32-1:0] mask_o,
    input logic                invalid_o,
    input logic                valid_o
);
    logic snan_seen;

    // Independent scan for signaling NaNs in any lane of either operand.
    always_comb begin
        snan_seen = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (a_i[i*32+30 -: 8] == 8'hFF && a_i[i*32+21 -: 22] != '0 && !a_i[i*32+22])
                snan_seen = 1'b1;
            if (b_i[i*32+30 -: 8] == 8'hFF && b_i[i*32+21 -: 22] != '0 && !b_i[i*32+22])
                snan_seen = 1'b1;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(mask_o) && $stable(invalid_o))) else $error("hold"); // R2

    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(valid_i)) else $error("valid"); // R2

    AST_FALSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && imm_i[3:0] == 4'd11) |=> (mask_o == '0)) else $error("false"); // R6

    AST_TRUE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && imm_i[3:0] == 4'd15) |=> (mask_o == '1)) else $error("true"); // R6

    AST_ORDQ_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && imm_i == 5'd7) |=> (invalid_o == $past(snan_seen))) else $error("ordq"); // R9

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        AST_LANE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (mask_o[i*32 +: 32] == '0 || mask_o[i*32 +: 32] == '1))
            else $error("lane"); // R7
    end
endmodule

bind fcmp_packed_unit fcmp_packed_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .valid_i   (valid_i),
    .mask_o    (mask_o),
    .invalid_o (invalid_o),
    .valid_o   (valid_o)
);

// File: tb/tb_fcmp_packed_unit.sv
// Self-checking bench: directed corner cases plus seeded random vectors,
// compared against a reference model built from the requirements.
module tb_fcmp_packed_unit;
    localparam int LANES    = 8;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 100000;
    localparam int NRAND    = 3000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES*32-1:0] a_i = '0, b_i = '0;
    logic [4:0]          imm_i = '0;
    logic                valid_i = 1'b0;
    logic [LANES*32-1:0] mask_o;
    logic                invalid_o, valid_o;

    logic [31:0] va [LANES];
    logic [31:0] vb [LANES];
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    fcmp_packed_unit #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .valid_i(valid_i), .mask_o(mask_o), .invalid_o(invalid_o), .valid_o(valid_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d expected < %0d cycles", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic bit is_nan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && x[22] == 1'b0;
    endfunction
    // Monotone unsigned key of a non-NaN value, zeros folded together.
    function automatic logic [31:0] okey(logic [31:0] x);
        logic [31:0] y = (x[30:0] == 0) ? 32'h0 : x;
        return y[31] ? ~y : (y ^ 32'h8000_0000);
    endfunction
    // 0 less, 1 equal, 2 greater, 3 unordered
    function automatic int ref_rel(logic [31:0] x, logic [31:0] y);
        if (is_nan(x) || is_nan(y)) return 3;
        if (okey(x) < okey(y)) return 0;
        if (okey(x) == okey(y)) return 1;
        return 2;
    endfunction
    function automatic bit ref_holds(logic [4:0] c, int r);
        bit lt = (r == 0), eq = (r == 1), gt = (r == 2), un = (r == 3);
        case (c[3:0])
            0: return eq;          1: return lt;
            2: return lt || eq;    3: return un;
            4: return !eq;         5: return !lt;
            6: return !(lt || eq); 7: return !un;
            8: return eq || un;    9: return !(gt || eq);
            10: return !gt;        11: return 1'b0;
            12: return !(eq || un); 13: return gt || eq;
            14: return gt;         default: return 1'b1;
        endcase
    endfunction
    function automatic bit ref_sig(logic [4:0] c);
        bit s;
        case (c[3:0])
            1, 2, 5, 6, 9, 10, 13, 14: s = 1'b1;
            default: s = 1'b0;
        endcase
        return s ^ c[4];
    endfunction

    task automatic check(string tag, logic [LANES*32-1:0] am, logic [LANES*32-1:0] em,
                         logic ai, logic ei, logic av, logic ev);
        n_chk++;
        if (am !== em || ai !== ei || av !== ev) begin
            n_fail++;
            $display("FAIL %s: act mask=%h inv=%b v=%b expected mask=%h inv=%b v=%b",
                     tag, am, ai, av, em, ei, ev);
        end
    endtask

    // Drive va/vb with code c for one cycle and check the registered result.
    task automatic apply(string tag, logic [4:0] c);
        logic [LANES*32-1:0] em;
        logic ei = 1'b0;
        bit s = ref_sig(c);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            a_i[i*32 +: 32] = va[i];
            b_i[i*32 +: 32] = vb[i];
            em[i*32 +: 32] = {32{ref_holds(c, ref_rel(va[i], vb[i]))}};
            if (s ? (is_nan(va[i]) || is_nan(vb[i])) : (is_snan(va[i]) || is_snan(vb[i])))
                ei = 1'b1;
        end
        imm_i = c; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, mask_o, em, invalid_o, ei, valid_o, 1'b1);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 9))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return {$urandom_range(0, 1) == 1, 31'h7F80_0000};
            3: return {$urandom_range(0, 1) == 1, 9'h1FF, 22'($urandom_range(0, 4194303))};
            4: return {$urandom_range(0, 1) == 1, 9'h1FE, 22'($urandom_range(1, 4194303))};
            5: return {$urandom_range(0, 1) == 1, 31'h3F80_0000};
            default: return $urandom();
        endcase
    endfunction

    task automatic fill(logic [31:0] x, logic [31:0] y);
        for (int i = 0; i < LANES; i++) begin va[i] = x; vb[i] = y; end
    endtask

    initial begin
        logic [LANES*32-1:0] held;
        void'($urandom(32'h5EED_0C3A));
        repeat (3) @(negedge clk);
        check("R1 reset", mask_o, '0, invalid_o, 1'b0, valid_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", mask_o, '0, invalid_o, 1'b0, valid_o, 1'b0);

        // R3: signed zeros, negative ordering
        fill(32'h0000_0000, 32'h8000_0000); apply("R3 zero eq", 5'd0);
        fill(32'hC000_0000, 32'hBF80_0000); apply("R3 neg lt", 5'd1);
        fill(32'h3F80_0000, 32'hBF80_0000); apply("R3 pos gt", 5'd14);
        // R4: infinities ordered, NaN unordered
        fill(32'h7F80_0000, 32'h7F80_0000); apply("R4 inf ordered", 5'd3);
        fill(32'h7FC0_0000, 32'h3F80_0000); apply("R4 nan unord", 5'd3);

        // R5/R6/R7: mixed-relation lanes over every code
        va[0] = 32'h3F80_0000; vb[0] = 32'h4000_0000;
        va[1] = 32'h8000_0000; vb[1] = 32'h0000_0000;
        va[2] = 32'h7F80_0000; vb[2] = 32'hFF80_0000;
        va[3] = 32'h7FC0_0001; vb[3] = 32'h0000_0000;
        va[4] = 32'hC120_0000; vb[4] = 32'hC110_0000;
        va[5] = 32'h0000_0001; vb[5] = 32'h0000_0000;
        va[6] = 32'h4240_0000; vb[6] = 32'h4240_0000;
        va[7] = 32'h3F80_0000; vb[7] = 32'hFFC0_0000;
        for (int c = 0; c < 32; c++)
            apply(c < 16 ? "R5 R7 code sweep" : "R6 R7 code sweep", 5'(c));

        // R8/R9: quiet vs signaling NaN handling, constant predicates
        fill(32'h7FC0_0000, 32'h3F80_0000);
        apply("R9 quiet qnan", 5'd0);
        apply("R8 sig qnan", 5'd1);
        apply("R8 inverted quiet", 5'd17);
        apply("R8 inverted sig", 5'd16);
        fill(32'h7F80_0001, 32'h3F80_0000);
        apply("R9 quiet snan", 5'd0);
        apply("R9 false snan", 5'd11);
        apply("R9 true snan", 5'd15);
        apply("R9 false sig snan", 5'd27);
        // R10: single NaN in top lane
        fill(32'h3F80_0000, 32'h3F80_0000);
        vb[LANES-1] = 32'hFF80_0003;
        apply("R10 top lane snan", 5'd7);
        va[LANES-1] = 32'h3F80_0000; vb[LANES-1] = 32'h7FC0_0000;
        apply("R10 top lane qnan sig", 5'd13);

        // R2: hold without valid while inputs change
        held = mask_o;
        @(negedge clk);
        a_i = ~a_i; imm_i = 5'd15;
        @(negedge clk);
        check("R2 hold", mask_o, held, invalid_o, 1'b1, valid_o, 1'b0);

        for (int n = 0; n < NRAND; n++) begin
            for (int i = 0; i < LANES; i++) begin
                va[i] = pick();
                vb[i] = ($urandom_range(0, 5) == 0) ? va[i] : pick();
            end
            apply("R5 R6 R9 random", 5'($urandom_range(0, 31)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule